// File: doc/BRIEF.md
# Mailbox Command Processor

This block sits on the device side of a pair of four-byte mailboxes. A host reaches it through a byte-wide register bus. The host loads a 16-bit argument into two outgoing bytes and then writes an 8-bit command code. The block runs the command for a fixed number of clocks. It then updates one of its stored settings, or reads a value back. Last, it posts a 16-bit result and copies the command code into an echo byte. The host watches the echo byte to learn that the command has finished. A separate incoming byte carries an 8-bit input status. The block samples this status from isolated inputs at a fixed interval.

Completion is shown only by the echo matching the issued code. Before issuing the same code a second time, the host sends the clear command, so that the next completion can be seen. Settings that the block stores go to the peripherals through a one-cycle write strobe. That strobe carries the command code and the 16-bit value. The register bus has no back-pressure: a read returns data in the same cycle, and a write is taken or dropped in one cycle. While a command is running, writes to the outgoing bytes are dropped.

Top module: `mbx_cmd_proc`

## Requirements
- R1: After reset, all eight mailbox bytes read 0x00, `dout` is 0x00, `busy` is low and `cfg_we` is low.
- R2: A write to address 2 (the command byte) starts a command whose argument is {address 1, address 0}. Writes to addresses 0, 1 and 3 on their own start nothing: `busy` stays low and the echo byte keeps its value.
- R3: The result (address 4 low byte, address 5 high byte) and the echo (address 6) change together, exactly EXEC_CYCLES clocks after the edge that accepts the command write. `busy` is high from that edge until they change.
- R4: Code 0x00 sets the echo byte to 0x00 and the result to 0x0000, so that a repeated code gives a fresh completion.
- R5: Code 0x01 drives `dout` with the argument's low byte and returns that byte zero-extended. Code 0x02 returns `dout` zero-extended. `dout` never changes while no command is running.
- R6: Codes SET_BASE to SET_BASE+NSET-1 (default 0x10 to 0x4F) store the argument and return it. Each of these codes, and code 0x01, raises `cfg_we` for exactly one cycle at completion, with `cfg_code` equal to the code and `cfg_data` equal to the stored value.
- R7: Code 0x07 takes a code in the argument's low byte and returns the latest value stored with that code. For code 0x01 it returns `dout`, and for any code that stores nothing it returns 0x0000.
- R8: Code 0x0E returns FW_VER and code 0x0F returns HW_VER.
- R9: Any other code still completes with an echo. It returns 0x0000 and changes no setting and no `dout`.
- R10: While `busy` is high, writes to addresses 0 to 3 are dropped: they neither change the readback value nor start a command. Writes to addresses 4 to 7 are always ignored.
- R11: The byte at address 3 is stored and reads back. Its value has no effect on how a command executes.
- R12: Address 7 shows `din` after a two-flop synchroniser, captured once every SAMPLE_CYCLES clocks. A steady `din` appears there within SAMPLE_CYCLES+2 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte address: 0-3 outgoing, 4-7 incoming |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| din | input | 8 | Isolated input levels, asynchronous |
| dout | output | 8 | Output state set by code 0x01 |
| busy | output | 1 | Command in execution |
| cfg_we | output | 1 | One-cycle setting write strobe |
| cfg_code | output | 8 | Code of the setting written |
| cfg_data | output | 16 | Value of the setting written |

## Verification
Suppose the execution counter or state register goes wrong. The echo then arrives early, arrives late, or never arrives. This is visible at address 6 at the exact cycle the bench computes from EXEC_CYCLES, so the failure appears within one command. If the settings store or the code decode is wrong, the damage stays hidden until the value is read back with code 0x07. So each stored value is read back right after it is written, and the edges of the settable range are checked too. A dropped-write fault while busy shows at once as a changed outgoing-byte readback, or as a second echo that should not appear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] CMD_CLEAR    = 8'h00;
  localparam logic [7:0] CMD_SET_OUT  = 8'h01;
  localparam logic [7:0] CMD_GET_OUT  = 8'h02;
  localparam logic [7:0] CMD_READBACK = 8'h07;
  localparam logic [7:0] CMD_FW_VER   = 8'h0E;
  localparam logic [7:0] CMD_HW_VER   = 8'h0F;

  typedef enum logic {ST_IDLE, ST_RUN} exec_state_t;

  typedef struct packed {
    logic [7:0]  code;
    logic [15:0] arg;
  } mbx_cmd_t;
endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        busy,
  input  logic [15:0] fb,
  input  logic [7:0]  echo,
  input  logic [7:0]  status,
  output logic        start,
  output mbx_cmd_t    cmd
);
  logic [7:0] omb_q [4];
  logic       out_wr;

  assign out_wr = bus_wr && !bus_addr[2] && !busy;
  assign start  = out_wr && (bus_addr[1:0] == 2'd2);
  assign cmd    = '{code: bus_wdata, arg: {omb_q[1], omb_q[0]}};

  for (genvar g = 0; g < 4; g++) begin : g_omb
    always_ff @(posedge clk) begin
      if (!rst_n)
        omb_q[g] <= 8'h00;
      else if (out_wr && bus_addr[1:0] == 2'(g))
        omb_q[g] <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      3'd4:    bus_rdata = fb[7:0];
      3'd5:    bus_rdata = fb[15:8];
      3'd6:    bus_rdata = echo;
      3'd7:    bus_rdata = status;
      default: bus_rdata = omb_q[bus_addr[1:0]];
    endcase
  end
endmodule

// File: rtl/mbx_din_sampler.sv
module mbx_din_sampler #(
  parameter int W             = 8,
  parameter int SAMPLE_CYCLES = 5000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] status
);
  localparam int TW = $clog2(SAMPLE_CYCLES) + 1;

  logic [W-1:0]  sync_q;
  logic [TW-1:0] tick_cnt;
  logic          tick;

  for (genvar b = 0; b < W; b++) begin : g_sync
    logic meta_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q    <= 1'b0;
        sync_q[b] <= 1'b0;
      end else begin
        meta_q    <= din[b];
        sync_q[b] <= meta_q;
      end
    end
  end

  assign tick = (tick_cnt == TW'(SAMPLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      status   <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (tick)
        status <= sync_q;
    end
  end
endmodule

// File: rtl/mbx_exec.sv
module mbx_exec
  import mbx_pkg::*;
#(
  parameter int          EXEC_CYCLES = 8,
  parameter int          SET_BASE    = 16,
  parameter int          NSET        = 64,
  parameter logic [15:0] FW_VER      = 16'h0103,
  parameter logic [15:0] HW_VER      = 16'h0201
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mbx_cmd_t    cmd,
  output logic        busy,
  output logic [7:0]  echo,
  output logic [15:0] fb,
  output logic [7:0]  dout,
  output logic        cfg_we,
  output logic [7:0]  cfg_code,
  output logic [15:0] cfg_data
);
  localparam int         CNT_W    = $clog2(EXEC_CYCLES) + 1;
  localparam int         IDX_W    = (NSET > 1) ? $clog2(NSET) : 1;
  localparam logic [7:0] SET_LO   = 8'(SET_BASE);
  localparam logic [7:0] SET_HI   = 8'(SET_BASE + NSET - 1);

  exec_state_t state;
  logic [CNT_W-1:0] cnt;
  mbx_cmd_t   cur;
  logic [15:0] store [NSET];

  logic        done;
  logic        is_set, is_out;
  logic [IDX_W-1:0] set_idx, rb_idx;
  logic        rb_is_set;
  logic [7:0]  rb_code;
  logic [15:0] rb_val, fb_n, wr_val;

  assign busy    = (state == ST_RUN);
  assign done    = busy && (cnt == '0);
  assign is_out  = (cur.code == CMD_SET_OUT);
  assign is_set  = (cur.code >= SET_LO) && (cur.code <= SET_HI);
  assign set_idx = IDX_W'(cur.code - SET_LO);
  assign rb_code = cur.arg[7:0];
  assign rb_is_set = (rb_code >= SET_LO) && (rb_code <= SET_HI);
  assign rb_idx  = IDX_W'(rb_code - SET_LO);
  assign wr_val  = is_out ? {8'h00, cur.arg[7:0]} : cur.arg;

  always_comb begin
    if (rb_code == CMD_SET_OUT)
      rb_val = {8'h00, dout};
    else if (rb_is_set)
      rb_val = store[rb_idx];
    else
      rb_val = 16'h0000;
  end

  always_comb begin
    fb_n = 16'h0000;
    if (is_out || is_set)
      fb_n = wr_val;
    else begin
      case (cur.code)
        CMD_GET_OUT:  fb_n = {8'h00, dout};
        CMD_READBACK: fb_n = rb_val;
        CMD_FW_VER:   fb_n = FW_VER;
        CMD_HW_VER:   fb_n = HW_VER;
        default:      fb_n = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cur      <= '0;
      echo     <= 8'h00;
      fb       <= 16'h0000;
      dout     <= 8'h00;
      cfg_we   <= 1'b0;
      cfg_code <= 8'h00;
      cfg_data <= 16'h0000;
    end else begin
      cfg_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cur   <= cmd;
            cnt   <= CNT_W'(EXEC_CYCLES - 1);
            state <= ST_RUN;
          end
        end
        default: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            echo  <= cur.code;
            fb    <= fb_n;
            if (is_out)
              dout <= cur.arg[7:0];
            if (is_out || is_set) begin
              cfg_we   <= 1'b1;
              cfg_code <= cur.code;
              cfg_data <= wr_val;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < NSET; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rst_n)
        store[g] <= 16'h0000;
      else if (done && is_set && set_idx == IDX_W'(g))
        store[g] <= cur.arg;
    end
  end
endmodule

// File: rtl/mbx_cmd_proc.sv
module mbx_cmd_proc
  import mbx_pkg::*;
#(
  parameter int          EXEC_CYCLES   = 8,
  parameter int          SAMPLE_CYCLES = 5000,
  parameter int          SET_BASE      = 16,
  parameter int          NSET          = 64,
  parameter logic [15:0] FW_VER        = 16'h0103,
  parameter logic [15:0] HW_VER        = 16'h0201
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        busy,
  output logic        cfg_we,
  output logic [7:0]  cfg_code,
  output logic [15:0] cfg_data
);
  logic        start_w;
  mbx_cmd_t    cmd_w;
  logic [15:0] fb_w;
  logic [7:0]  echo_w;
  logic [7:0]  status_w;

  mbx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .fb(fb_w), .echo(echo_w), .status(status_w),
    .start(start_w), .cmd(cmd_w)
  );

  mbx_exec #(
    .EXEC_CYCLES(EXEC_CYCLES), .SET_BASE(SET_BASE), .NSET(NSET),
    .FW_VER(FW_VER), .HW_VER(HW_VER)
  ) u_exec (
    .clk(clk), .rst_n(rst_n), .start(start_w), .cmd(cmd_w),
    .busy(busy), .echo(echo_w), .fb(fb_w), .dout(dout),
    .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_data(cfg_data)
  );

  mbx_din_sampler #(
    .W(8), .SAMPLE_CYCLES(SAMPLE_CYCLES)
  ) u_samp (
    .clk(clk), .rst_n(rst_n), .din(din), .status(status_w)
  );
endmodule

// File: rtl/mbx_cmd_proc_chk.sv
module mbx_cmd_proc_chk #(
  parameter int EXEC_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [7:0] echo,
  input logic [7:0] dout,
  input logic       cfg_we
);
  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      run_cnt <= 0;
    else
      run_cnt <= busy ? run_cnt + 1 : 0;
  end

  AST_EXEC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < EXEC_CYCLES)); // R3
  AST_ECHO_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(echo)); // R3
  AST_DOUT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(dout)); // R5
  AST_CFG_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> $fell(busy)); // R6
  AST_CFG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !cfg_we); // R6
endmodule

bind mbx_cmd_proc mbx_cmd_proc_chk #(.EXEC_CYCLES(EXEC_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .echo(echo_w),
  .dout(dout), .cfg_we(cfg_we)
);

// File: tb/tb_mbx_cmd_proc.sv
module tb_mbx_cmd_proc;
  localparam int EXEC = 8;
  localparam int SAMP = 5000;
  localparam logic [15:0] FW = 16'h0103;
  localparam logic [15:0] HW = 16'h0201;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00, din = 8'h00;
  logic [7:0] bus_rdata, dout, cfg_code;
  logic busy, cfg_we;
  logic [15:0] cfg_data;

  int checks = 0, errors = 0, cfg_cnt = 0;
  logic [7:0] last_code;
  logic [15:0] last_data;
  bit done = 0;

  always #10 clk = ~clk;

  mbx_cmd_proc dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .dout(dout),
    .busy(busy), .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_data(cfg_data)
  );

  always @(negedge clk) if (cfg_we) begin
    cfg_cnt++; last_code = cfg_code; last_data = cfg_data;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd_fb(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd4, lo); rd(3'd5, hi); v = {hi, lo};
  endtask

  task automatic issue(logic [7:0] code, logic [15:0] arg);
    wr(3'd0, arg[7:0]); wr(3'd1, arg[15:8]); wr(3'd3, 8'h00); wr(3'd2, code);
    repeat (EXEC) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); check("R1 reset byte", v, 0);
    end
    check("R1 dout", dout, 0); check("R1 busy", busy, 0); check("R1 cfg_we", cfg_we, 0);
  endtask

  task automatic t_latency();
    logic [7:0] e; logic [15:0] f;
    wr(3'd0, 8'h3C); wr(3'd1, 8'h00); wr(3'd2, 8'h01);
    repeat (EXEC - 1) @(negedge clk);
    rd(3'd6, e); check("R3 echo before done", e, 0); check("R3 busy", busy, 1);
    @(negedge clk);
    rd(3'd6, e); check("R3 echo at done", e, 8'h01); check("R3 busy low", busy, 0);
    rd_fb(f); check("R5 set out feedback", f, 16'h003C); check("R5 dout", dout, 8'h3C);
    check("R6 cfg code 01", last_code, 8'h01); check("R6 cfg data 01", last_data, 16'h003C);
  endtask

  task automatic t_get_and_clear();
    logic [7:0] e; logic [15:0] f;
    issue(8'h02, 16'h0000); rd_fb(f); check("R5 get out", f, 16'h003C);
    issue(8'h00, 16'h0000); rd(3'd6, e); check("R4 clear echo", e, 0);
    rd_fb(f); check("R4 clear result", f, 0);
    issue(8'h02, 16'h0000); rd(3'd6, e); check("R4 repeat echo", e, 8'h02);
  endtask

  task automatic t_param_only();
    logic [7:0] e;
    issue(8'h00, 16'h0000);
    wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd3, 8'h33);
    check("R2 no start busy", busy, 0);
    repeat (EXEC + 2) @(negedge clk);
    rd(3'd6, e); check("R2 no start echo", e, 0);
  endtask

  task automatic t_settings();
    logic [15:0] f; int n;
    n = cfg_cnt;
    issue(8'h15, 16'hBEEF); rd_fb(f); check("R6 set feedback", f, 16'hBEEF);
    check("R6 cfg count", cfg_cnt - n, 1);
    check("R6 cfg code", last_code, 8'h15); check("R6 cfg data", last_data, 16'hBEEF);
    issue(8'h4F, 16'h1357); issue(8'h10, 16'h2468);
    issue(8'h07, 16'h0015); rd_fb(f); check("R7 readback 15", f, 16'hBEEF);
    issue(8'h07, 16'h004F); rd_fb(f); check("R7 readback top", f, 16'h1357);
    issue(8'h07, 16'h0010); rd_fb(f); check("R7 readback base", f, 16'h2468);
    issue(8'h07, 16'h0001); rd_fb(f); check("R7 readback out", f, 16'h003C);
    issue(8'h07, 16'h0003); rd_fb(f); check("R7 readback none", f, 0);
  endtask

  task automatic t_versions();
    logic [15:0] f;
    issue(8'h0E, 16'h0000); rd_fb(f); check("R8 fw", f, FW);
    issue(8'h0F, 16'h0000); rd_fb(f); check("R8 hw", f, HW);
  endtask

  task automatic t_unknown();
    logic [7:0] e; logic [15:0] f; int n;
    n = cfg_cnt;
    issue(8'h50, 16'h1234); rd(3'd6, e); check("R9 echo 50", e, 8'h50);
    rd_fb(f); check("R9 result 50", f, 0);
    issue(8'h9C, 16'h5678); rd(3'd6, e); check("R9 echo 9C", e, 8'h9C);
    rd_fb(f); check("R9 result 9C", f, 0);
    check("R9 dout kept", dout, 8'h3C); check("R9 no cfg", cfg_cnt - n, 0);
    issue(8'h07, 16'h0050); rd_fb(f); check("R9 nothing stored", f, 0);
  endtask

  task automatic t_busy_drop();
    logic [7:0] v; logic [15:0] f;
    issue(8'h0F, 16'h0042);
    wr(3'd2, 8'h0E); wr(3'd0, 8'hAA); wr(3'd2, 8'h02);
    repeat (EXEC) @(negedge clk);
    rd(3'd6, v); check("R10 echo first only", v, 8'h0E);
    rd_fb(f); check("R10 result first", f, FW);
    rd(3'd0, v); check("R10 byte0 kept", v, 8'h42);
    repeat (EXEC + 2) @(negedge clk);
    rd(3'd6, v); check("R10 no second cmd", v, 8'h0E);
    wr(3'd6, 8'h77); wr(3'd4, 8'h77);
    rd(3'd6, v); check("R10 incoming write ignored", v, 8'h0E);
    rd(3'd4, v); check("R10 result write ignored", v, FW[7:0]);
  endtask

  task automatic t_byte3();
    logic [7:0] v; logic [15:0] f;
    wr(3'd0, 8'h21); wr(3'd1, 8'h43); wr(3'd3, 8'hFF); wr(3'd2, 8'h20);
    repeat (EXEC) @(negedge clk);
    rd(3'd3, v); check("R11 byte3 readback", v, 8'hFF);
    rd_fb(f); check("R11 result unaffected", f, 16'h4321);
    rd(3'd2, v); check("R2 cmd byte readback", v, 8'h20);
  endtask

  task automatic t_din();
    logic [7:0] v;
    din = 8'hA5; repeat (SAMP + 4) @(negedge clk);
    rd(3'd7, v); check("R12 status A5", v, 8'hA5);
    din = 8'h3C; repeat (SAMP + 4) @(negedge clk);
    rd(3'd7, v); check("R12 status 3C", v, 8'h3C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_get_and_clear();
    t_param_only();
    t_settings();
    t_versions();
    t_unknown();
    t_busy_drop();
    t_byte3();
    t_din();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule